// File: doc/BRIEF.md
# Registered Read-Only Store with Multi-Role Output Control

This block is a byte-wide read-only store whose read port is a pipeline register: on every rising clock edge the word at the presented address is captured, and the outputs only move at that edge. Address changes between edges have no visible effect. A data flag beside the byte stands in for a three-state bus: when it is low the byte is don't-care.

One control input, `ctl_n`, has three possible roles. A stored configuration byte chooses the role:
- In immediate-enable mode it gates the outputs combinationally.
- In clocked-enable mode its level is sampled at each rising edge.
- In start-word mode the outputs stay on, and a low level puts a stored start word on the outputs at once. Clock edges are blocked until the pin returns high.

Contents, the start word and the configuration byte are written through a synchronous load port before operation. With the default parameters the store holds 4096 words. Setting `ADDR_W` to 13 gives the full 8192-word array.

Top module: `prom_registered`

## Requirements
- R1: While `rst_n` is low at a rising edge, the pipeline register is cleared. After such an edge `dout` reads 0, and `dout_oe` follows the immediate-enable rule.
- R2: At each rising edge outside start-word hold, the word at `addr` is captured and shown on `dout` from that edge on. An `addr` change between edges leaves `dout` unchanged.
- R3: With `ld_en` high at a rising edge, the load port writes according to `ld_addr`:
  - `ld_addr` below 2^ADDR_W writes that data word.
  - 2^ADDR_W writes the start word.
  - 2^ADDR_W+1 writes the configuration byte.
  - Any higher `ld_addr` writes nothing.
- R4: The configuration byte selects the mode: 0 selects immediate enable, 1 clocked enable, and 2 start-word mode. Any other value behaves as 0. A written value governs from the edge that writes it onward.
- R5: In immediate-enable mode, `dout_oe` equals the inverse of `ctl_n` at all times, without waiting for a clock edge.
- R6: In clocked-enable mode, `dout_oe` changes only at rising edges, taking the inverse of `ctl_n` sampled at that edge.
- R7: In start-word mode, `dout_oe` is always 1. While `ctl_n` is low, `dout` equals the start word with no clock edge needed.
- R8: In start-word mode, rising edges with `ctl_n` low capture nothing. After `ctl_n` returns high, `dout` keeps the start word until the next rising edge, which captures the addressed word. This holds even for a low pulse that spans no edge.
- R9: Reset clears the start word and the configuration byte. After reset the block is in immediate-enable mode, and a start-word load yields 0. A start word of all ones yields all ones.
- R10: With `ld_en` low, nothing is written, whatever `ld_addr` and `ld_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Read address |
| ctl_n | input | 1 | Multi-role control input (enable or start-word load, active low) |
| ld_en | input | 1 | Load-port write strobe |
| ld_addr | input | ADDR_W+1 | Load-port location |
| ld_data | input | DATA_W | Load-port write value |
| dout | output | DATA_W | Pipeline register value, or start word during start-word load |
| dout_oe | output | 1 | Output enable; `dout` is meaningful only when high |

## Verification
The bench builds the block with `ADDR_W` = 4 and `DATA_W` = 8. With these values every data word can be filled and read back. The start-word and configuration locations (16 and 17) sit directly above the array, and a load address such as 19 aliases data word 3 if the top address bit is dropped. This makes the load-port decode and the out-of-range case reachable in a few cycles. The small array also leaves room to walk each of the three modes through their edge-aligned and edge-free transitions, including a start-word pulse that spans no clock edge.

// File: rtl/prom_reg_pkg.sv
// Shared definitions for the registered read-only store.
// Assumes: configuration values are compared against small constants only.
package prom_reg_pkg;

    // Role of the multi-purpose control input
    typedef enum logic [1:0] {
        MODE_IMM_EN  = 2'd0,
        MODE_CLK_EN  = 2'd1,
        MODE_START   = 2'd2
    } ctl_mode_e;

    localparam int unsigned CFG_CODE_CLK_EN = 1;
    localparam int unsigned CFG_CODE_START  = 2;

endpackage

// File: rtl/prom_store.sv
// Word array plus the pipeline register on its read port.
// Assumes: writes come only from the load-port decoder; the array has no
// reset (contents are loaded before use); the pipeline register is cleared
// by synchronous reset and captures only when cap_en is high.
module prom_store #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] pipe_q
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Array write from the load port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Pipeline capture of the addressed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else if (cap_en) begin
            pipe_q <= words[rd_addr];
        end
    end
endmodule

// File: rtl/prom_cfg_regs.sv
// Load-port decoder, start-word register and configuration register.
// Assumes: the load port is written before operation; locations at and above
// 2^ADDR_W+2 are ignored; undefined configuration codes decode as immediate
// enable.
module prom_cfg_regs
    import prom_reg_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W:0]   ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic              data_we,
    output logic [ADDR_W-1:0] data_waddr,
    output logic [DATA_W-1:0] start_word,
    output ctl_mode_e         mode
);
    localparam logic [ADDR_W:0] START_LOC = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0] CFG_LOC   = START_LOC + 1'b1;

    logic [DATA_W-1:0] cfg_q;
    logic              wr_ok;

    // Writes are taken only outside reset with the strobe high
    always_comb begin
        wr_ok      = ld_en && rst_n;
        data_we    = wr_ok && !ld_addr[ADDR_W];
        data_waddr = ld_addr[ADDR_W-1:0];
    end

    // Start-word and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_word <= '0;
            cfg_q      <= '0;
        end else if (wr_ok) begin
            if (ld_addr == START_LOC) start_word <= ld_data;
            if (ld_addr == CFG_LOC)   cfg_q      <= ld_data;
        end
    end

    // Mode decode with fallback for undefined codes
    always_comb begin
        if (cfg_q == DATA_W'(CFG_CODE_CLK_EN))     mode = MODE_CLK_EN;
        else if (cfg_q == DATA_W'(CFG_CODE_START)) mode = MODE_START;
        else                                       mode = MODE_IMM_EN;
    end
endmodule

// File: rtl/prom_out_ctl.sv
// Output enable and output select for the three control roles.
// Assumes: in start-word mode a low control level asynchronously marks the
// start word as held; the hold clears at the first rising edge seen with the
// control high, which is the same edge at which the store captures again.
module prom_out_ctl
    import prom_reg_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_mode_e         mode,
    input  logic              ctl_n,
    input  logic [DATA_W-1:0] start_word,
    input  logic [DATA_W-1:0] pipe_q,
    output logic              start_req,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    logic start_hold;
    logic clk_oe_q;

    // Active start-word request
    always_comb begin
        start_req = (mode == MODE_START) && !ctl_n;
    end

    // Hold flag: set at once by the request, cleared by a later clean edge
    always_ff @(posedge clk or posedge start_req) begin
        if (start_req) begin
            start_hold <= 1'b1;
        end else begin
            start_hold <= 1'b0;
        end
    end

    // Edge-sampled enable for clocked-enable mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_oe_q <= 1'b1;
        end else begin
            clk_oe_q <= !ctl_n;
        end
    end

    // Output data and enable selection
    always_comb begin
        dout = (start_req || start_hold) ? start_word : pipe_q;
        unique case (mode)
            MODE_CLK_EN: dout_oe = clk_oe_q;
            MODE_START:  dout_oe = 1'b1;
            default:     dout_oe = !ctl_n;
        endcase
    end
endmodule

// File: rtl/prom_registered.sv
// Top level: registered read-only store with a multi-role control input.
// Assumes: contents, start word and configuration are loaded through the
// load port after reset and before normal reads.
module prom_registered
    import prom_reg_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ctl_n,
    input  logic              ld_en,
    input  logic [ADDR_W:0]   ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    logic              data_we;
    logic [ADDR_W-1:0] data_waddr;
    logic [DATA_W-1:0] start_word;
    logic [DATA_W-1:0] pipe_q;
    logic              start_req;
    ctl_mode_e         cur_mode;

    prom_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_en),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .data_we    (data_we),
        .data_waddr (data_waddr),
        .start_word (start_word),
        .mode       (cur_mode)
    );

    prom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (data_we),
        .wr_addr (data_waddr),
        .wr_data (ld_data),
        .cap_en  (!start_req),
        .rd_addr (addr),
        .pipe_q  (pipe_q)
    );

    prom_out_ctl #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (cur_mode),
        .ctl_n      (ctl_n),
        .start_word (start_word),
        .pipe_q     (pipe_q),
        .start_req  (start_req),
        .dout       (dout),
        .dout_oe    (dout_oe)
    );
endmodule

// File: rtl/prom_registered_chk.sv
// Property checker for prom_registered, attached by bind below.
// Assumes: sampled at rising clock edges, quiet during reset.
module prom_registered_chk
    import prom_reg_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_n,
    input logic              ld_en,
    input logic [ADDR_W:0]   ld_addr,
    input logic [DATA_W-1:0] ld_data,
    input ctl_mode_e         mode,
    input logic [DATA_W-1:0] start_word,
    input logic [DATA_W-1:0] pipe_q,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe
);
    localparam logic [ADDR_W:0] START_LOC = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0] CFG_LOC   = START_LOC + 1'b1;

    // R3
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_addr == START_LOC) |=> (start_word == $past(ld_data)));

    // R4
    cfg_clk_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_addr == CFG_LOC && ld_data == DATA_W'(1)) |=> (mode == MODE_CLK_EN));

    // R5
    imm_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IMM_EN) |-> (dout_oe == !ctl_n));

    // R6
    clk_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CLK_EN && $past(mode) == MODE_CLK_EN && $past(rst_n))
            |-> (dout_oe == !$past(ctl_n)));

    // R7
    start_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_START) |-> dout_oe);

    // R7
    start_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_START && !ctl_n) |-> (dout == start_word));

    // R8
    start_blocks_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode == MODE_START && !ctl_n) |=> $stable(pipe_q));
endmodule

bind prom_registered prom_registered_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_n      (ctl_n),
    .ld_en      (ld_en),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .mode       (cur_mode),
    .start_word (start_word),
    .pipe_q     (pipe_q),
    .dout       (dout),
    .dout_oe    (dout_oe)
);

// File: tb/prom_registered_test.sv
module prom_registered_test;
    localparam int unsigned AW = 4;
    localparam int unsigned DW = 8;
    localparam logic [AW:0] START_LOC = 5'd16;
    localparam logic [AW:0] CFG_LOC   = 5'd17;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ctl_n;
    logic          ld_en;
    logic [AW:0]   ld_addr;
    logic [DW-1:0] ld_data;
    logic [DW-1:0] dout;
    logic          dout_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    prom_registered #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ctl_n(ctl_n),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .dout(dout), .dout_oe(dout_oe)
    );

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 37 + 11) & 8'hFF);
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [AW:0] a, input logic [DW-1:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        tick();
        ld_en = 1'b0;
    endtask

    // Vector: {addr, ctl_n, expected oe}, immediate-enable mode, one edge each
    localparam logic [5:0] VEC [8] = '{
        {4'd0, 1'b0, 1'b1}, {4'd7, 1'b0, 1'b1}, {4'd15, 1'b1, 1'b0}, {4'd15, 1'b0, 1'b1},
        {4'd1, 1'b0, 1'b1}, {4'd9, 1'b1, 1'b0}, {4'd9, 1'b0, 1'b1}, {4'd12, 1'b0, 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; ctl_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        @(negedge clk);
        tick(); tick();
        // R1: reset clears the register, enable follows ctl_n
        chk("R1 data", dout, 8'h00);
        chk("R1 oe", {7'd0, dout_oe}, 8'd1);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) load(5'(i), pat(i));

        // R2 R5: table walk in immediate-enable mode
        for (int v = 0; v < 8; v++) begin
            addr = VEC[v][5:2]; ctl_n = VEC[v][1];
            tick();
            chk("R5 oe", {7'd0, dout_oe}, {7'd0, VEC[v][0]});
            if (VEC[v][0]) chk("R2 data", dout, pat(int'(VEC[v][5:2])));
        end

        // R2: address change between edges has no effect
        ctl_n = 1'b0; addr = 4'd5; tick();
        addr = 4'd9; #1;
        chk("R2 hold", dout, pat(5));
        tick();
        chk("R2 next", dout, pat(9));

        // R5: enable reacts with no clock edge
        ctl_n = 1'b1; #1;
        chk("R5 off", {7'd0, dout_oe}, 8'd0);
        ctl_n = 1'b0; #1;
        chk("R5 on", {7'd0, dout_oe}, 8'd1);

        // R10: write with strobe low is ignored
        ld_addr = 5'd3; ld_data = 8'hEE; tick();
        addr = 4'd3; tick();
        chk("R10", dout, pat(3));

        // R3: load address above the map is ignored (would alias word 3)
        load(5'd19, 8'hEE);
        tick();
        chk("R3 range", dout, pat(3));

        // R4: undefined code 7 behaves as immediate enable
        load(CFG_LOC, 8'h07);
        ctl_n = 1'b1; #1;
        chk("R4 fallback", {7'd0, dout_oe}, 8'd0);
        ctl_n = 1'b0;

        // R6: clocked enable
        load(CFG_LOC, 8'h01);
        ctl_n = 1'b1; #1;
        chk("R6 wait", {7'd0, dout_oe}, 8'd1);
        tick();
        chk("R6 off", {7'd0, dout_oe}, 8'd0);
        ctl_n = 1'b0; #1;
        chk("R6 still off", {7'd0, dout_oe}, 8'd0);
        tick();
        chk("R6 on", {7'd0, dout_oe}, 8'd1);
        chk("R6 data", dout, pat(3));

        // R7 R8: start-word mode
        load(START_LOC, 8'hA5);
        ctl_n = 1'b1;
        load(CFG_LOC, 8'h02);
        addr = 4'd6; tick();
        chk("R7 oe", {7'd0, dout_oe}, 8'd1);
        chk("R7 normal", dout, pat(6));
        ctl_n = 1'b0; #1;
        chk("R7 immediate", dout, 8'hA5);
        addr = 4'd10; tick(); tick(); tick();
        chk("R8 blocked", dout, 8'hA5);
        chk("R7 oe low", {7'd0, dout_oe}, 8'd1);
        ctl_n = 1'b1; #1;
        chk("R8 held", dout, 8'hA5);
        tick();
        chk("R8 resume", dout, pat(10));
        // R8: pulse spanning no edge
        ctl_n = 1'b0; #1; ctl_n = 1'b1; #1;
        chk("R8 short pulse", dout, 8'hA5);
        tick();
        chk("R8 short resume", dout, pat(10));
        // R9: all-ones start word acts as preset
        load(START_LOC, 8'hFF);
        ctl_n = 1'b0; #1;
        chk("R9 preset", dout, 8'hFF);
        ctl_n = 1'b1; tick();

        // R9: reset clears start word and configuration
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        ctl_n = 1'b1; #1;
        chk("R9 mode", {7'd0, dout_oe}, 8'd0);
        ctl_n = 1'b0;
        load(CFG_LOC, 8'h02);
        chk("R9 start word", dout, 8'h00);
        ctl_n = 1'b1; tick();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule